// File: doc/BRIEF.md
# Horizontal Two-Phase Panel Clock Generator

This block drives the horizontal scan of an active-matrix display panel. A line sync pulse starts a line. The block then emits two complementary sampling clocks. Each half-period of these clocks is one step, and each step samples six dots of the line at the same time. A start pulse tells the panel's horizontal shift register where the line begins. The number of steps in a line depends on the display mode. This lets the panel blank its edges and keep a smaller picture centred.

All timing counts cycles of a faster reference clock. One step lasts `HALF_DIV` reference cycles. The start pulse is set up one full step ahead of the clock edge that captures it, and it is held for `HST_HOLD` cycles after that edge. The capturing edge depends on the scan direction. In the normal direction the rising edge of the first phase captures the pulse. In reverse, the following edge captures it, where the first phase falls and the second rises. Mode and direction are sampled once at each line sync, so a change on those inputs part-way through a line has no effect until the next sync.

Top module: `hscan_clkgen`

## Requirements
- R1: While reset is asserted, and after reset until the first line sync, `hst`, `hck1`, `hck2` and `line_act` are all low.
- R2: The number of steps per line is set by the `mode_sel` code sampled at sync: 0 gives 140 steps, 1 gives 134, 2 gives 128, 3 and 4 give 108, and the unused codes 5, 6 and 7 also give 108. `line_act` therefore stays high for exactly steps × `HALF_DIV` reference cycles.
- R3: Every step lasts `HALF_DIV` reference cycles. `hck1` is high on even steps (counting from 0) and `hck2` is high on odd steps, so the two clocks never overlap and each clock's edge falls on the same cycle as the opposite edge of the other clock. Outside the steps of a line, both clocks are low.
- R4: `line_act` is high from the first cycle of step 0 to the last cycle of the final step, and low at all other times.
- R5: With `scan_fwd` = 1 sampled at sync, `hst` is high for the `HALF_DIV` cycles before step 0 and for the first `HST_HOLD` cycles of step 0. At all other times it is low.
- R6: With `scan_fwd` = 0 sampled at sync, `hst` is low before step 0. It is high for all of step 0 and for the first `HST_HOLD` cycles of step 1, and low at all other times.
- R7: A line sync that arrives while a line (or its lead-in) is in progress abandons that line. In the cycle after the sync, a fresh lead-in begins, using the newly sampled mode and direction.
- R8: Changes on `mode_sel` or `scan_fwd` between syncs do not change the length, clock pattern or start pulse of the line in progress.
- R9: After a sync, a lead-in of `HALF_DIV` cycles comes before step 0. During the lead-in both clocks and `line_act` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sync | input | 1 | Line start request, sampled on each rising clock edge |
| mode_sel | input | 3 | Display mode code, which sets the steps per line |
| scan_fwd | input | 1 | Scan direction: 1 is normal, 0 is reverse |
| hst | output | 1 | Horizontal start pulse to the panel |
| hck1 | output | 1 | First sampling clock phase |
| hck2 | output | 1 | Second sampling clock phase, the complement of the first during a line |
| line_act | output | 1 | High while line steps are being emitted |

## Verification
The bench builds the block with `HALF_DIV` = 3 and `HST_HOLD` = 2. With an odd half-period, an off-by-one in the tick counter shows up as a clock step of the wrong length instead of cancelling out. A hold of two cycles separates "hold ends at the tick limit" from "hold ends after one cycle" in both start-pulse variants. These small values keep even the 140-step line at about 430 cycles. That is short enough to run every mode code in both directions, and to add restarts in the lead-in, restarts in the middle of a line, and a sync held high for several cycles.

// File: rtl/hscan_pkg.sv
package hscan_pkg;

  localparam int MAX_STEPS = 140;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_RUN  = 2'd2
  } line_phase_e;

  // steps per line for each mode code; unused codes fall back to the narrowest
  function automatic logic [STEP_W-1:0] steps_for_mode(input logic [2:0] code);
    case (code)
      3'd0:    return STEP_W'(140);
      3'd1:    return STEP_W'(134);
      3'd2:    return STEP_W'(128);
      default: return STEP_W'(108);
    endcase
  endfunction

endpackage

// File: rtl/hscan_step_timer.sv
module hscan_step_timer
  import hscan_pkg::*;
#(
  parameter int HALF_DIV = 4,
  localparam int TICK_W  = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_sync,
  input  logic [2:0]        mode_sel,
  input  logic              scan_fwd,
  output line_phase_e       phase_q,
  output logic [TICK_W-1:0] tick_q,
  output logic [STEP_W-1:0] step_q,
  output logic              dir_q
);

  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(HALF_DIV - 1);

  logic [STEP_W-1:0] n_steps_q;

  // named internal events
  logic step_end;
  logic last_step;
  logic line_done;

  assign step_end  = (tick_q == TICK_LAST);
  assign last_step = (step_q == n_steps_q - STEP_W'(1));
  assign line_done = (phase_q == PH_RUN) && step_end && last_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      tick_q    <= '0;
      step_q    <= '0;
      n_steps_q <= STEP_W'(MAX_STEPS);
      dir_q     <= 1'b1;
    end else if (line_sync) begin
      phase_q   <= PH_LEAD;
      tick_q    <= '0;
      step_q    <= '0;
      n_steps_q <= steps_for_mode(mode_sel);
      dir_q     <= scan_fwd;
    end else begin
      case (phase_q)
        PH_LEAD: begin
          if (step_end) begin
            phase_q <= PH_RUN;
            tick_q  <= '0;
          end else begin
            tick_q <= tick_q + TICK_W'(1);
          end
        end
        PH_RUN: begin
          if (step_end) begin
            tick_q <= '0;
            if (last_step) begin
              phase_q <= PH_IDLE;
              step_q  <= '0;
            end else begin
              step_q <= step_q + STEP_W'(1);
            end
          end else begin
            tick_q <= tick_q + TICK_W'(1);
          end
        end
        default: begin
          tick_q <= '0;
          step_q <= '0;
        end
      endcase
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN) |-> (step_q < n_steps_q)); // R2

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    line_sync |=> (phase_q == PH_LEAD && tick_q == '0 && step_q == '0)); // R7

  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_sync |=> ($stable(n_steps_q) && $stable(dir_q))); // R8

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !line_sync) |=> (phase_q == PH_IDLE)); // R2

endmodule

// File: rtl/hscan_phase_decode.sv
module hscan_phase_decode
  import hscan_pkg::*;
#(
  parameter int TICK_W   = 2,
  parameter int HST_HOLD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_phase_e       phase_q,
  input  logic [TICK_W-1:0] tick_q,
  input  logic [STEP_W-1:0] step_q,
  input  logic              dir_q,
  output logic              hst,
  output logic              hck1,
  output logic              hck2,
  output logic              line_act
);

  localparam logic [TICK_W-1:0] HOLD_T = TICK_W'(HST_HOLD);

  logic in_run;
  logic in_lead;
  logic on_step0;
  logic on_step1;
  logic in_hold;
  logic hst_fwd;
  logic hst_rev;

  assign in_run   = (phase_q == PH_RUN);
  assign in_lead  = (phase_q == PH_LEAD);
  assign on_step0 = in_run && (step_q == '0);
  assign on_step1 = in_run && (step_q == STEP_W'(1));
  assign in_hold  = (tick_q < HOLD_T);

  // normal: captured by first rising hck1; reverse: captured at the hck1 fall
  assign hst_fwd = in_lead || (on_step0 && in_hold);
  assign hst_rev = on_step0 || (on_step1 && in_hold);

  always_comb begin
    line_act = in_run;
    hck1     = in_run && !step_q[0];
    hck2     = in_run &&  step_q[0];
    hst      = dir_q ? hst_fwd : hst_rev;
  end

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hck1 && hck2)); // R3

  AST_LEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LEAD) |-> (!hck1 && !hck2 && !line_act)); // R9

  AST_HST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    hst |-> (phase_q != PH_IDLE && step_q <= STEP_W'(1))); // R5

endmodule

// File: rtl/hscan_clkgen.sv
module hscan_clkgen
  import hscan_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int HST_HOLD = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_sync,
  input  logic [2:0] mode_sel,
  input  logic       scan_fwd,
  output logic       hst,
  output logic       hck1,
  output logic       hck2,
  output logic       line_act
);

  localparam int TICK_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

  line_phase_e       phase_q;
  logic [TICK_W-1:0] tick_q;
  logic [STEP_W-1:0] step_q;
  logic              dir_q;

  hscan_step_timer #(
    .HALF_DIV (HALF_DIV)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_sync (line_sync),
    .mode_sel  (mode_sel),
    .scan_fwd  (scan_fwd),
    .phase_q   (phase_q),
    .tick_q    (tick_q),
    .step_q    (step_q),
    .dir_q     (dir_q)
  );

  hscan_phase_decode #(
    .TICK_W   (TICK_W),
    .HST_HOLD (HST_HOLD)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_q  (phase_q),
    .tick_q   (tick_q),
    .step_q   (step_q),
    .dir_q    (dir_q),
    .hst      (hst),
    .hck1     (hck1),
    .hck2     (hck2),
    .line_act (line_act)
  );

  AST_IDLE_CLOCKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !line_act |-> (!hck1 && !hck2)); // R3

  AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (line_act && $past(line_act) && $rose(hck2)) |-> $fell(hck1)); // R3

  AST_ACT_HAS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    line_act |-> $countones({hck1, hck2}) == 1); // R4

endmodule

// File: tb/hscan_clkgen_test.sv
module hscan_clkgen_test;

  localparam int H    = 3;
  localparam int HOLD = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_sync = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic       scan_fwd = 1'b1;
  wire        hst, hck1, hck2, line_act;

  always #4 clk = ~clk;

  hscan_clkgen #(.HALF_DIV(H), .HST_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .mode_sel(mode_sel),
    .scan_fwd(scan_fwd), .hst(hst), .hck1(hck1), .hck2(hck2), .line_act(line_act)
  );

  int    pos = -1;
  int    m_n = 0;
  bit    m_dir = 1'b1;
  bit    ended = 1'b0;
  int    dut_run = 0;
  int    vectors = 0;
  int    errors = 0;
  int    cyc = 0;
  string focus = "";

  function automatic int steps_of(input int code);
    if (code == 0) return 140;
    if (code == 1) return 134;
    if (code == 2) return 128;
    return 108;
  endfunction

  // behavioural reference: position in the line, in reference cycles since sync
  always @(posedge clk) begin
    ended = 1'b0;
    if (!rst_n) pos = -1;
    else if (line_sync) begin
      pos = 0; m_n = steps_of(int'(mode_sel)); m_dir = scan_fwd;
    end else if (pos >= 0) begin
      pos++;
      if (pos >= (1 + m_n) * H) begin pos = -1; ended = 1'b1; end
    end
  end

  task automatic check(input bit got, input bit exp, input string req, input string what);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s%s: %s actual=%0b expected=%0b (pos %0d)", req, focus, what, got, exp, pos);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    bit e1, e2, ea, eh;
    int s, t;
    string rq_clk, rq_hst;
    e1 = 0; e2 = 0; ea = 0; eh = 0;
    rq_clk = "R3"; rq_hst = m_dir ? "R5" : "R6";
    if (!rst_n || pos < 0) begin
      if (!rst_n) begin rq_clk = "R1"; rq_hst = "R1"; end
    end else if (pos < H) begin
      rq_clk = "R9";
      eh = m_dir;
    end else begin
      s = (pos - H) / H; t = (pos - H) % H;
      ea = 1; e1 = (s % 2 == 0); e2 = (s % 2 == 1);
      eh = m_dir ? (s == 0 && t < HOLD) : (s == 0 || (s == 1 && t < HOLD));
    end
    check(hck1, e1, rq_clk, "hck1");
    check(hck2, e2, rq_clk, "hck2");
    check(line_act, ea, rst_n ? "R4" : "R1", "line_act");
    check(hst, eh, rq_hst, "hst");
    if (pos == 0) dut_run = 0;
    if (line_act === 1'b1) dut_run++;
    if (ended) check(dut_run == m_n * H, 1'b1, "R2", "line length matches mode");
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected<=200000", cyc);
      report();
    end
  end

  task automatic start_line(input int code, input bit fwd);
    @(negedge clk);
    mode_sel = 3'(code); scan_fwd = fwd; line_sync = 1'b1;
    @(negedge clk);
    line_sync = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);                       // R1 checked while reset is held
    rst_n = 1'b1;
    idle(6);                       // R1 idle after reset
    for (int m = 0; m < 8; m++) begin
      start_line(m, (m % 2) == 0); // R2 per code, R5/R6 by direction
      idle(20);
      focus = " [R8 inputs changed mid-line]";
      mode_sel = ~3'(m); scan_fwd = ~scan_fwd;
      idle(steps_of(m) * H + H + 4 - 20);
      focus = "";
    end
    // R7: restart in the middle of a line with new mode and direction
    start_line(0, 1'b1);
    idle(60);
    focus = " [R7 restart]";
    start_line(3, 1'b0);
    idle(108 * H + H + 4);
    // R7: restart during lead-in
    start_line(1, 1'b0);
    start_line(2, 1'b1);
    idle(128 * H + H + 4);
    // R7: sync held high for three cycles
    @(negedge clk);
    mode_sel = 3'd4; scan_fwd = 1'b0; line_sync = 1'b1;
    idle(3);
    line_sync = 1'b0;
    idle(108 * H + H + 4);
    focus = "";
    // back-to-back lines: sync on the cycle right after a line ends
    start_line(2, 1'b1);
    idle(128 * H + H - 1);
    start_line(1, 1'b0);
    idle(134 * H + H + 4);
    report();
  end

endmodule